// File: doc/BRIEF.md
# Real-Time Clock Prescaler with Trim Correction

This block turns a 32.768 kHz input clock into a once-per-second tick for a real-time clock's calendar counters. The division ratio and a fractional trim correction live together in one 32-bit configuration word that software reaches over a simple single-cycle register bus. The trim deletes a programmable number of input cycles from one second out of every few seconds. This lets the long-term rate be corrected for a crystal that runs slightly fast or slow.

The configuration word resets to zero, and a zero word means the prescaler is not yet initialized. While the word is zero the counter is held and no tick is produced. Software that reads zero knows it must program the divider. Each rising edge of the tick sets a sticky flag in a status word. The flag is cleared by writing one to it. An enable bit in the same word gates the flag onto an interrupt output.

All logic runs in the input clock domain: every clock cycle is one input cycle.

Top module: `rtc_prescaler`

## Requirements
- R1: After reset the configuration word (offset 0x0C) reads 0, the status word (offset 0x08) reads 0, and the tick and interrupt outputs are low.
- R2: While the configuration word is zero the tick output stays low, and the word reads back as zero.
- R3: With divider value N in bits [15:0] and a trim interval of 0 in bits [31:26], successive ticks are exactly N+1 cycles apart, whatever the trim count is.
- R4: With trim interval I>0 in bits [31:26] and trim count D in bits [25:16], every I-th period after a configuration write lasts N+1-D cycles and the others last N+1 cycles.
- R5: When D is at least N, a shortened period lasts exactly one cycle.
- R6: A write to the configuration word restarts division: the first tick is high in the (N+1)-th cycle after the write edge, and the trim interval count starts over.
- R7: A write to the configuration word stores all 32 bits, and the word reads back unchanged.
- R8: Status bit 1 is set on each rising edge of the tick and stays set. Status bits other than 1 and 3 read 0.
- R9: Writing 1 to status bit 1 clears the flag. Writing 0 to it leaves the flag unchanged.
- R10: Status bit 3 is a read/write interrupt enable. The interrupt output is high exactly when both the flag and the enable are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz input clock; one cycle is one input cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset: 0x08 status, 0x0C configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| tick_1hz | output | 1 | One-cycle tick that ends each divided period |
| irq_1hz | output | 1 | Tick interrupt: flag AND enable |

## Verification
On every cycle, the assertions check four things. No tick appears while the configuration word is zero. The divider count never passes the programmed divider. The trim interval count stays below the interval. The flag holds until a clear is written, and the interrupt never rises without its enable. Only the bench's scenarios can show the exact spacing between ticks: the untrimmed period, the shortened period in a trimmed pattern, the one-cycle saturation and the restart delay after a write. The same holds for the read-back values and the order of write-one-to-clear steps against a pending flag.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
    localparam int DATA_W  = 32;
    localparam int DIV_W   = 16;
    localparam int DEL_W   = 10;
    localparam int IVL_W   = DATA_W - DIV_W - DEL_W;

    localparam logic [7:0] ADDR_STAT = 8'h08;
    localparam logic [7:0] ADDR_CFG  = 8'h0C;
    localparam int FLAG_BIT = 1;
    localparam int EN_BIT   = 3;

    // Field order fixes the bit positions software uses.
    typedef struct packed {
        logic [IVL_W-1:0] ivl;
        logic [DEL_W-1:0] del;
        logic [DIV_W-1:0] div;
    } cfg_t;

    // Terminal count of a shortened period, saturating at zero.
    function automatic logic [DIV_W-1:0] trimmed_limit(
        input logic [DIV_W-1:0] div, input logic [DEL_W-1:0] del);
        logic [DIV_W-1:0] d_ext;
        d_ext = DIV_W'(del);
        if (d_ext >= div) return '0;
        return div - d_ext;
    endfunction
endpackage

// File: rtl/rtcp_divider.sv
module rtcp_divider
    import rtcp_pkg::*;
#(
    parameter bit TRIM_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg,
    input  logic restart,
    output logic tick
);
    logic [DIV_W-1:0] cnt;
    logic [IVL_W-1:0] icnt;
    logic             running;
    logic             short_per;
    logic [DIV_W-1:0] limit;

    assign running = (cfg != '0);

    generate
        if (TRIM_EN) begin : g_trim
            assign short_per = (cfg.ivl != '0) && (icnt == cfg.ivl - IVL_W'(1));
            assign limit     = short_per ? trimmed_limit(cfg.div, cfg.del) : cfg.div;
        end else begin : g_notrim
            assign short_per = 1'b0;
            assign limit     = cfg.div;
        end
    endgenerate

    assign tick = running && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt  <= '0;
            icnt <= '0;
        end else if (running) begin
            if (tick) begin
                cnt <= '0;
                if (cfg.ivl == '0 || short_per) icnt <= '0;
                else                            icnt <= icnt + IVL_W'(1);
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

    // R3: the count never passes the programmed divider
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        running |-> cnt <= cfg.div);

    // R4: the interval count stays inside the interval
    a_r4_ivl_bound: assert property (@(posedge clk) disable iff (rst)
        (cfg.ivl != '0) |-> icnt < cfg.ivl);
endmodule

// File: rtl/rtcp_regs.sv
module rtcp_regs
    import rtcp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick,
    output cfg_t              cfg,
    output logic              restart,
    output logic              flag,
    output logic              en
);
    logic tick_q;
    logic rise;
    logic wr_stat;
    logic clr;

    assign restart = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_CFG));
    assign wr_stat = bus_sel && bus_wr && (bus_addr == ADDR_W'(ADDR_STAT));
    assign clr     = wr_stat && bus_wdata[FLAG_BIT];
    assign rise    = tick && !tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            en     <= 1'b0;
            flag   <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= tick;
            if (restart) cfg <= cfg_t'(bus_wdata);
            if (wr_stat) en  <= bus_wdata[EN_BIT];
            flag <= rise | (flag & ~clr);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == ADDR_W'(ADDR_CFG)) begin
                bus_rdata = DATA_W'(cfg);
            end else if (bus_addr == ADDR_W'(ADDR_STAT)) begin
                bus_rdata[FLAG_BIT] = flag;
                bus_rdata[EN_BIT]   = en;
            end
        end
    end

    // R9: the flag holds unless a clear is written
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        flag && !clr |=> flag);

    // R9: a clear with no new edge empties the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr && !rise |=> !flag);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtcp_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter bit TRIM_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_1hz,
    output logic              irq_1hz
);
    cfg_t cfg;
    logic restart;
    logic flag;
    logic en;

    rtcp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick      (tick_1hz),
        .cfg       (cfg),
        .restart   (restart),
        .flag      (flag),
        .en        (en)
    );

    rtcp_divider #(.TRIM_EN(TRIM_EN)) u_div (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .restart (restart),
        .tick    (tick_1hz)
    );

    assign irq_1hz = flag & en;

    // R2: an uninitialized prescaler produces no tick
    a_r2_halt: assert property (@(posedge clk) disable iff (rst)
        (cfg == '0) |-> !tick_1hz);

    // R8: a rising tick leaves the flag set
    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        $rose(tick_1hz) |=> flag);

    // R10: no interrupt without the enable
    a_r10_irq_en: assert property (@(posedge clk) disable iff (rst)
        irq_1hz |-> en);
endmodule

// File: tb/rtc_prescaler_test.sv
module rtc_prescaler_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        tick_1hz;
    logic        irq_1hz;

    int n_chk = 0;
    int n_fail = 0;

    rtc_prescaler uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_1hz(tick_1hz), .irq_1hz(irq_1hz)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge; the write happens at the rising edge between.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Counts falling edges from the current one (1) until the tick is seen.
    task automatic wait_tick(output int k);
        k = 1;
        while (!tick_1hz && k < 2000) begin
            @(negedge clk);
            k++;
        end
        if (!tick_1hz) k = -1;
    endtask

    task automatic next_period(output int p);
        @(negedge clk);
        p = 1;
        while (!tick_1hz && p < 2000) begin
            @(negedge clk);
            p++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        int seen;
        rd(8'h0C, d); check(d == 0, "R1 cfg reset", int'(d), 0);
        rd(8'h08, d); check(d == 0, "R1 status reset", int'(d), 0);
        check(irq_1hz == 0, "R1 irq reset", int'(irq_1hz), 0);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tick_1hz) seen++;
        end
        check(seen == 0, "R2 no tick when uninitialized", seen, 0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        int seen;
        wr(8'h0C, 32'hA5A5_1234);
        rd(8'h0C, d); check(d == 32'hA5A5_1234, "R7 readback", int'(d), int'(32'hA5A5_1234));
        wr(8'h0C, 32'h0);
        rd(8'h0C, d); check(d == 0, "R2 zero readback", int'(d), 0);
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tick_1hz) seen++;
        end
        check(seen == 0, "R2 halted after zero write", seen, 0);
    endtask

    task automatic t_plain;
        int k, p;
        // N=9, D=5 but interval 0: trim inactive
        wr(8'h0C, 32'h0005_0009);
        wait_tick(k); check(k == 10, "R6 first tick after write", k, 10);
        for (int i = 0; i < 3; i++) begin
            next_period(p); check(p == 10, "R3 untrimmed period", p, 10);
        end
        wr(8'h0C, 32'h0000_001F);
        wait_tick(k); check(k == 32, "R6 restart N=31", k, 32);
        next_period(p); check(p == 32, "R3 period N=31", p, 32);
    endtask

    task automatic t_trim;
        int k, p;
        int exp_seq[5] = '{20, 15, 20, 20, 15};
        // N=19, D=5, I=3
        wr(8'h0C, {6'd3, 10'd5, 16'd19});
        wait_tick(k); check(k == 20, "R4 first period", k, 20);
        foreach (exp_seq[i]) begin
            next_period(p); check(p == exp_seq[i], "R4 trimmed pattern I=3", p, exp_seq[i]);
        end
        // N=9, D=3, I=1: every period short
        wr(8'h0C, {6'd1, 10'd3, 16'd9});
        wait_tick(k); check(k == 7, "R4 I=1 first period", k, 7);
        next_period(p); check(p == 7, "R4 I=1 period", p, 7);
    endtask

    task automatic t_sat;
        int k, hi;
        // N=4, D=10, I=1: shortened period of one cycle, tick stays high
        wr(8'h0C, {6'd1, 10'd10, 16'd4});
        wait_tick(k); check(k == 1, "R5 saturated first tick", k, 1);
        hi = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (tick_1hz) hi++;
        end
        check(hi == 5, "R5 one-cycle periods", hi, 5);
    endtask

    task automatic t_flag;
        logic [31:0] d;
        int k;
        wr(8'h0C, 32'h0000_001D);        // N=29
        wr(8'h08, 32'h0000_0002);        // clear, enable off
        rd(8'h08, d); check(d == 0, "R9 clear before test", int'(d), 0);
        wait_tick(k);
        @(negedge clk);
        rd(8'h08, d); check(d == 32'h2, "R8 flag set, other bits zero", int'(d), 2);
        check(irq_1hz == 0, "R10 irq masked", int'(irq_1hz), 0);
        wr(8'h08, 32'h0000_0008);        // enable, write 0 to flag
        rd(8'h08, d); check(d == 32'hA, "R9 zero write keeps flag", int'(d), 10);
        check(irq_1hz == 1, "R10 irq with enable", int'(irq_1hz), 1);
        wr(8'h08, 32'h0000_000A);        // clear, keep enable
        rd(8'h08, d); check(d == 32'h8, "R9 one write clears flag", int'(d), 8);
        check(irq_1hz == 0, "R10 irq after clear", int'(irq_1hz), 0);
        wait_tick(k);
        @(negedge clk);
        check(irq_1hz == 1, "R8 next tick sets flag again", int'(irq_1hz), 1);
        wr(8'h08, 32'h0000_0000);        // disable
        check(irq_1hz == 0, "R10 irq after disable", int'(irq_1hz), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_readback();
        t_plain();
        t_trim();
        t_sat();
        t_flag();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule